// File: doc/BRIEF.md
# Execute-Stage ALU with Persistent Condition Flags

This block is the execute unit of a single-cycle, 32-bit load/store core. In one cycle it applies one of five integer operations to two operands and produces a result and a zero indication that the branch logic consumes. Beside the arithmetic it holds four status bits: carry, overflow, zero and negative. They are kept between instructions, so software can query the outcome of an earlier register-to-register operation long after it retired.

The surrounding decoder presents each instruction already sorted into a class: register-to-register, flag read-back, or anything else. Only the register-to-register class writes the status bits, on the rising clock edge that ends its cycle. The read-back class replaces the result with the stored bits, zero-extended, and leaves them as they are. Every other class computes normally and does not touch the stored bits.

Top module: `alu_cc_exec`

## Requirements
- R1: `alu_sel` picks the operation: 4'b0000 bitwise AND, 4'b0001 bitwise OR, 4'b0010 add, 4'b0110 subtract (a minus b), 4'b0111 signed set-less-than giving 1 or 0. Any other code gives an ALU result of zero.
- R2: When `instr_kind` is 2'b01 (register-to-register), the four status bits are loaded on the rising clock edge from the ALU outcome of that cycle.
- R3: When `instr_kind` is 2'b00 (other), 2'b10 (read-back) or 2'b11 (treated as other), the status bits keep their value across the edge.
- R4: When `instr_kind` is 2'b10, `result` carries the stored bits with carry at bit 3, overflow at bit 2, zero at bit 1 and negative at bit 0, and bits 31 to 4 are zero.
- R5: Carry is the carry out of bit 31 for add. For subtract it is 1 when a is greater than or equal to b as unsigned numbers, which means no borrow. It is 0 for every other code.
- R6: Overflow is 1 when an add or subtract overflows as a signed operation. It is 0 for every other code.
- R7: The zero status bit is 1 exactly when the 32-bit ALU result is all zeros. The negative bit equals bit 31 of the ALU result.
- R8: `zero` is combinational and equals 1 exactly when the ALU result of the present operands and code is all zeros, in every instruction class, the read-back class included.
- R9: A synchronous active-high `rst` clears all four status bits, so a read-back right after reset returns 0.
- R10: For every class other than read-back, `result` equals the ALU result combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status bits load on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the status bits |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_sel | input | 4 | Operation code |
| instr_kind | input | 2 | Pre-decoded instruction class |
| result | output | 32 | ALU result, or the packed status bits for read-back |
| zero | output | 1 | All-zero indication of the ALU result, for branches |

## Verification
The clocked properties assume that `instr_kind` and `alu_sel` are valid, known values at every rising edge once reset is released, and that operands change only between edges. The immediate checks on the result multiplexer and the arithmetic likewise assume known inputs. The bench drives every input once per cycle on the falling edge, starting at time zero, so no property sees an unknown class code. It holds reset for its first cycles before it expects any stored value.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int unsigned SEL_W  = 4;
  localparam int unsigned KIND_W = 2;
  localparam int unsigned CC_W   = 4;

  localparam logic [SEL_W-1:0] OP_AND = 4'b0000;
  localparam logic [SEL_W-1:0] OP_OR  = 4'b0001;
  localparam logic [SEL_W-1:0] OP_ADD = 4'b0010;
  localparam logic [SEL_W-1:0] OP_SUB = 4'b0110;
  localparam logic [SEL_W-1:0] OP_SLT = 4'b0111;

  localparam logic [KIND_W-1:0] KIND_OTHER = 2'b00;
  localparam logic [KIND_W-1:0] KIND_RREG  = 2'b01;
  localparam logic [KIND_W-1:0] KIND_RDCC  = 2'b10;

  // Packed order is behaviour: carry at the top, negative at bit 0.
  typedef struct packed {
    logic cy;
    logic ov;
    logic zr;
    logic ng;
  } cc_t;

endpackage

// File: rtl/alu_cc_arith.sv
module alu_cc_arith
  import alu_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SEL_W-1:0]  op,
  output logic [DATA_W-1:0] res,
  output cc_t               cc_next
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0] sum_w;
  logic [DATA_W:0] dif_w;
  logic            ov_add;
  logic            ov_sub;
  logic            lt_signed;

  always_comb begin
    sum_w  = {1'b0, a} + {1'b0, b};
    dif_w  = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, 1'b1};
    ov_add = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
    ov_sub = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
    lt_signed = dif_w[MSB] ^ ov_sub;
  end

  always_comb begin
    res        = '0;
    cc_next.cy = 1'b0;
    cc_next.ov = 1'b0;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_ADD: begin
        res        = sum_w[DATA_W-1:0];
        cc_next.cy = sum_w[DATA_W];
        cc_next.ov = ov_add;
      end
      OP_SUB: begin
        res        = dif_w[DATA_W-1:0];
        cc_next.cy = dif_w[DATA_W];
        cc_next.ov = ov_sub;
      end
      OP_SLT: res = {{(DATA_W-1){1'b0}}, lt_signed};
      default: res = '0;
    endcase
    cc_next.zr = (res == '0);
    cc_next.ng = res[MSB];
  end

  always_comb begin
    if (op == OP_ADD) begin
      AST_ADD_WIDE: assert ({cc_next.cy, res} == ({1'b0, a} + {1'b0, b})); // R5
    end
    if (op == OP_SUB) begin
      AST_SUB_NOBORROW: assert (cc_next.cy == (a >= b)); // R5
      AST_SUB_SOVF: assert (cc_next.ov == (($signed(a) < $signed(b)) != $signed(res) < 0)); // R6
    end
    if (op != OP_ADD && op != OP_SUB) begin
      AST_NONARITH_CLR: assert (!cc_next.cy && !cc_next.ov); // R6
    end
  end

endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg
  import alu_cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  cc_t               cc_d,
  output cc_t               cc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= '0;
    end else if (load) begin
      cc_q <= cc_d;
    end
  end

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (cc_q == '0)); // R9
  AST_LOAD_ON_R: assert property (@(posedge clk) disable iff (rst)
    load |=> (cc_q == $past(cc_d))); // R2
  AST_HOLD_OTHERS: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cc_q)); // R3

endmodule

// File: rtl/alu_cc_outmux.sv
module alu_cc_outmux
  import alu_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] alu_res,
  input  cc_t               cc_q,
  input  logic              rd_cc,
  output logic [DATA_W-1:0] res_out
);

  localparam int unsigned PAD_W = DATA_W - CC_W;

  logic [DATA_W-1:0] cc_word;

  generate
    if (PAD_W > 0) begin : g_pad
      assign cc_word = {{PAD_W{1'b0}}, cc_q};
    end else begin : g_nopad
      assign cc_word = cc_q[DATA_W-1:0];
    end
  endgenerate

  assign res_out = rd_cc ? cc_word : alu_res;

  always_comb begin
    if (rd_cc) begin
      AST_RDCC_UPPER_ZERO: assert ((res_out >> CC_W) == '0); // R4
      AST_RDCC_ORDER: assert (res_out[3] == cc_q.cy && res_out[0] == cc_q.ng); // R4
    end else if (rd_cc == 1'b0) begin
      AST_PASS_ALU: assert (res_out == alu_res); // R10
    end
  end

endmodule

// File: rtl/alu_cc_exec.sv
module alu_cc_exec
  import alu_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [3:0]        alu_sel,
  input  logic [1:0]        instr_kind,
  output logic [DATA_W-1:0] result,
  output logic              zero
);

  logic [DATA_W-1:0] alu_res;
  cc_t               cc_next;
  cc_t               cc_q;
  logic              is_rreg;
  logic              is_rdcc;

  assign is_rreg = (instr_kind == KIND_RREG);
  assign is_rdcc = (instr_kind == KIND_RDCC);

  alu_cc_arith #(.DATA_W(DATA_W)) u_arith (
    .a       (opnd_a),
    .b       (opnd_b),
    .op      (alu_sel),
    .res     (alu_res),
    .cc_next (cc_next)
  );

  alu_cc_flagreg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (is_rreg),
    .cc_d (cc_next),
    .cc_q (cc_q)
  );

  alu_cc_outmux #(.DATA_W(DATA_W)) u_mux (
    .alu_res (alu_res),
    .cc_q    (cc_q),
    .rd_cc   (is_rdcc),
    .res_out (result)
  );

  // Branch indication comes straight from the ALU, never from the stored bits.
  assign zero = (alu_res == '0);

  AST_ZERO_VS_RESULT: assert property (@(posedge clk) disable iff (rst)
    !is_rdcc |-> (zero == (result == '0))); // R8
  AST_STORED_Z_MATCH: assert property (@(posedge clk) disable iff (rst)
    is_rreg |=> (cc_q.zr == $past(zero))); // R7

endmodule

// File: tb/alu_cc_exec_test.sv
module alu_cc_exec_test;

  typedef struct {
    logic [31:0] res;
    logic        z;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [3:0]  alu_sel = '0;
  logic [1:0]  instr_kind = '0;
  logic [31:0] result;
  logic        zero;

  exp_t        sb_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [3:0]  m_cc = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu_cc_exec uut (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_sel(alu_sel), .instr_kind(instr_kind), .result(result), .zero(zero)
  );

  // Reference from the requirements: returns {C, O, result}.
  function automatic logic [33:0] ref_alu(input logic [31:0] a, input logic [31:0] b,
                                          input logic [3:0] s);
    longint sa, sb, ss;
    logic [31:0] r;
    logic c, o;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    c = 1'b0; o = 1'b0; r = '0;
    case (s)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b0010: begin
        r = a + b;
        c = ((64'(a) + 64'(b)) >> 32) != 0;
        ss = sa + sb;
        o = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      4'b0110: begin
        r = a - b;
        c = (a >= b);
        ss = sa - sb;
        o = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      4'b0111: r = (sa < sb) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
    return {c, o, r};
  endfunction

  task automatic drive(input logic [1:0] k, input logic [3:0] s,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [33:0] rv;
    exp_t e;
    @(negedge clk);
    instr_kind = k; alu_sel = s; opnd_a = a; opnd_b = b;
    rv = ref_alu(a, b, s);
    e.z = (rv[31:0] == 32'd0);
    e.res = (k == 2'b10) ? {28'd0, m_cc} : rv[31:0];
    e.tag = tag;
    sb_q.push_back(e);
    if (rst) m_cc = 4'd0;
    else if (k == 2'b01) m_cc = {rv[33], rv[32], rv[31:0] == 32'd0, rv[31]};
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst = 1'b1;
    instr_kind = 2'b00;
    m_cc = 4'd0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: compares mid-low-phase, after inputs settle and before the next edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_cmp++;
        if (result !== e.res || zero !== e.z) begin
          n_bad++;
          $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                   e.tag, result, zero, e.res, e.z);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive(2'b10, 4'b0000, 32'h0, 32'h0, "R9 reset state read-back");
    drive(2'b01, 4'b0000, 32'hFF00FF00, 32'h0F0F0F0F, "R1 R10 AND");
    drive(2'b10, 4'b0000, 32'h0, 32'h0, "R4 R8 read-back after AND");
    drive(2'b01, 4'b0010, 32'hFFFFFFFF, 32'h1, "R5 R7 add carry to zero");
    drive(2'b10, 4'b0001, 32'h1, 32'h0, "R4 flags C,Z");
    drive(2'b01, 4'b0010, 32'h7FFFFFFF, 32'h1, "R6 add signed overflow");
    drive(2'b10, 4'b0000, 32'h1, 32'h1, "R4 R6 flags O,N");
    drive(2'b01, 4'b0110, 32'h5, 32'h5, "R5 sub equal");
    drive(2'b10, 4'b0000, 32'h0, 32'h0, "R5 flags after equal sub");
    drive(2'b01, 4'b0110, 32'h3, 32'h5, "R5 R7 sub borrow");
    drive(2'b10, 4'b0000, 32'h0, 32'h0, "R7 flags after borrow");
    drive(2'b01, 4'b0110, 32'h80000000, 32'h1, "R6 sub signed overflow");
    drive(2'b00, 4'b0010, 32'hFFFFFFFF, 32'h1, "R3 R8 R10 other-class add");
    drive(2'b10, 4'b0000, 32'h0, 32'h0, "R3 flags held after other class");
    drive(2'b10, 4'b0001, 32'h0, 32'h0, "R3 read-back leaves flags");
    drive(2'b11, 4'b0001, 32'h0, 32'h0, "R3 class 11 as other");
    drive(2'b10, 4'b0000, 32'h0, 32'h0, "R3 flags held after class 11");
    drive(2'b01, 4'b0111, 32'hFFFFFFFF, 32'h1, "R1 SLT negative vs positive");
    drive(2'b10, 4'b0000, 32'h0, 32'h0, "R6 SLT clears C,O");
    drive(2'b01, 4'b0111, 32'h1, 32'hFFFFFFFF, "R1 SLT false");
    drive(2'b01, 4'b0001, 32'h80000000, 32'h00000010, "R1 R7 OR negative");
    drive(2'b01, 4'b1111, 32'h12345678, 32'h9ABCDEF0, "R1 undefined code");
    drive(2'b10, 4'b1111, 32'h5, 32'h6, "R1 R8 undefined code read-back");
    drive(2'b01, 4'b0010, 32'h80000000, 32'h80000000, "R5 R6 add both");
    pulse_reset();
    drive(2'b10, 4'b0000, 32'h0, 32'h0, "R9 reset clears flags");
    lf = 32'hACE1_2345;
    for (int i = 0; i < 60; i++) begin
      logic [3:0] sel;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (i % 6)
        0: sel = 4'b0000;
        1: sel = 4'b0001;
        2: sel = 4'b0010;
        3: sel = 4'b0110;
        4: sel = 4'b0111;
        default: sel = lf[7:4];
      endcase
      drive(2'(i % 3), sel, lf, {lf[15:0], lf[31:16]} ^ 32'(i), "R2 R10 mixed sequence");
    end
    drive(2'b10, 4'b0000, 32'h0, 32'h0, "R4 final read-back");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule